// File: doc/BRIEF.md
# Configurable Pin Interface Cell

This cell sits between one external pin group and one line of a crossbar fabric. A configuration word, written through a parallel load strobe, sets how the cell behaves. It sets the direction (input-only, output-only, bidirectional, or off). It sets the data handling: edge-registered, level-transparent, or pure pass-through. It also sets which lines of a shared control pool act as this cell's clock, clock enable, input enable and output enable. Many such cells share the same pool, and each cell picks its own lines from it.

The inbound path carries pin data to the crossbar. The outbound path carries crossbar data to the pin and its tristate enable. Both paths use the same storage mode, clock and clock enable. The pool clocks are sampled on the system clock. A registered capture happens at the first system edge where the chosen pool clock is seen high after being low. This keeps the whole cell in one clock domain.

Top module: `iocell_top`

## Requirements
- R1: After reset the configuration is all zeros: direction code 00 (off) and mode code 00 (pass-through). In this state pinOe, pinOut and xbarOut are all 0, whatever the pool and data inputs are.
- R2: A word on cfgData is loaded when cfgWe is high at a rising clk edge and takes effect after that edge. While cfgWe is low, cfgData has no effect. Field layout: bits [1:0] direction, [3:2] mode, then upward the clock select, the clock-enable select, the input-enable select and the output-enable select. With the default pool sizes these are bit 4, bits [6:5], bits [8:7] and bits [10:9].
- R3: Direction codes are 01 input-only, 10 output-only, 11 bidirectional and 00 off. Input-only and off keep pinOe and pinOut at 0. Output-only and off keep xbarOut at 0.
- R4: With an outbound direction (10 or 11), pinOe equals the pool output-enable line chosen by the output-enable select.
- R5: Mode 00 passes pinIn to xbarOut and xbarIn to pinOut within the same cycle, with no register on the way.
- R6: Mode 01 stores both paths at the first clk edge where the chosen pool clock is high after being low at the previous edge, and only when the chosen enable line is high. At every other edge the stored value holds, including while the pool clock stays high.
- R7: In mode 01, transitions on pool clocks that are not selected cause no capture.
- R8: In mode 10, both paths show their live inputs while the chosen clock-enable line is high. When that line goes low, they hold the value present at the last clk edge at which it was high.
- R9: When the chosen input-enable line is low, xbarOut is 0. The outbound path is not affected.
- R10: Mode code 11 behaves as pass-through.
- R11: The clock, clock-enable, input-enable and output-enable selects each index their own pool independently. The enable pool serves both the clock enable and the input enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration load strobe |
| cfgData | input | 11 | Configuration word |
| clkPool | input | NUM_CLK (2) | Shared pool clocks, sampled on clk |
| enPool | input | NUM_EN (4) | Shared enable lines (clock enable and input enable) |
| oePool | input | NUM_OE (4) | Shared output-enable lines |
| pinIn | input | DATA_W (1) | Data arriving from the pin |
| xbarIn | input | DATA_W (1) | Data arriving from the crossbar line |
| pinOut | output | DATA_W (1) | Data driven toward the pin |
| pinOe | output | 1 | Pin driver tristate enable |
| xbarOut | output | DATA_W (1) | Data delivered to the crossbar line |

## Verification
The bench widens the data paths to DATA_W = 4 and keeps two pool clocks and four enable and output-enable lines. The wider data lets distinct nibbles on the two paths show that the inbound and outbound lanes never swap or mix. The four-line pools let every select reach its top index (3), which tests the select decoders at their edge. With two pool clocks, a toggle on the unselected clock can be placed between registered captures, where it must cause no capture.

// File: rtl/iocell_pkg.sv
package iocell_pkg;

  typedef enum logic [1:0] {
    DIR_OFF   = 2'b00,
    DIR_IN    = 2'b01,
    DIR_OUT   = 2'b10,
    DIR_BIDIR = 2'b11
  } dir_e;

  typedef enum logic [1:0] {
    MODE_FLOW    = 2'b00,
    MODE_CLOCKED = 2'b01,
    MODE_LATCHED = 2'b10,
    MODE_RSVD    = 2'b11
  } mode_e;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic loadEn;      // write storage this cycle
    logic passLive;    // present the live input rather than the stored value
    logic inPath;      // direction allows the inbound lane
    logic outPath;     // direction allows the outbound lane
    logic inPass;      // inbound lane and input enable both active
    logic outDrive;    // pin driver enabled
    logic modeClocked; // registered mode decoded
  } strobe_t;

  localparam int LANE_IN  = 0;
  localparam int LANE_OUT = 1;
  localparam int NUM_LANES = 2;

endpackage

// File: rtl/iocell_pick.sv
module iocell_pick #(
  parameter int N     = 4,
  parameter int SEL_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     lines,
  input  logic [SEL_W-1:0] sel,
  output logic             hit
);
  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (sel == SEL_W'(i)) hit = lines[i];
    end
  end
endmodule

// File: rtl/iocell_ctrl.sv
module iocell_ctrl
  import iocell_pkg::*;
#(
  parameter int NUM_CLK = 2,
  parameter int NUM_EN  = 4,
  parameter int NUM_OE  = 4,
  localparam int CLK_SEL_W = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1,
  localparam int EN_SEL_W  = (NUM_EN  > 1) ? $clog2(NUM_EN)  : 1,
  localparam int OE_SEL_W  = (NUM_OE  > 1) ? $clog2(NUM_OE)  : 1,
  localparam int CFG_W     = 4 + CLK_SEL_W + 2 * EN_SEL_W + OE_SEL_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [CFG_W-1:0]   cfgData,
  input  logic [NUM_CLK-1:0] clkPool,
  input  logic [NUM_EN-1:0]  enPool,
  input  logic [NUM_OE-1:0]  oePool,
  output strobe_t            stb
);
  localparam int CLK_LO = 4;
  localparam int CE_LO  = CLK_LO + CLK_SEL_W;
  localparam int IE_LO  = CE_LO + EN_SEL_W;
  localparam int OE_LO  = IE_LO + EN_SEL_W;

  logic [CFG_W-1:0]   cfgQ;
  logic [NUM_CLK-1:0] clkPrev;

  dir_e                 dirQ;
  mode_e                modeQ;
  logic [CLK_SEL_W-1:0] clkSel;
  logic [EN_SEL_W-1:0]  ceSel;
  logic [EN_SEL_W-1:0]  ieSel;
  logic [OE_SEL_W-1:0]  oeSel;

  logic selClk, selClkPrev, ceLine, ieLine, oeLine, clkRise;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ    <= '0;
      clkPrev <= '0;
    end else begin
      if (cfgWe) cfgQ <= cfgData;
      clkPrev <= clkPool;
    end
  end

  assign dirQ   = dir_e'(cfgQ[1:0]);
  assign modeQ  = mode_e'(cfgQ[3:2]);
  assign clkSel = cfgQ[CE_LO-1:CLK_LO];
  assign ceSel  = cfgQ[IE_LO-1:CE_LO];
  assign ieSel  = cfgQ[OE_LO-1:IE_LO];
  assign oeSel  = cfgQ[CFG_W-1:OE_LO];

  iocell_pick #(.N(NUM_CLK)) uPickClk  (.lines(clkPool), .sel(clkSel), .hit(selClk));
  iocell_pick #(.N(NUM_CLK)) uPickPrev (.lines(clkPrev), .sel(clkSel), .hit(selClkPrev));
  iocell_pick #(.N(NUM_EN))  uPickCe   (.lines(enPool),  .sel(ceSel),  .hit(ceLine));
  iocell_pick #(.N(NUM_EN))  uPickIe   (.lines(enPool),  .sel(ieSel),  .hit(ieLine));
  iocell_pick #(.N(NUM_OE))  uPickOe   (.lines(oePool),  .sel(oeSel),  .hit(oeLine));

  assign clkRise = selClk & ~selClkPrev;

  always_comb begin
    stb = '0;
    unique case (modeQ)
      MODE_CLOCKED: begin
        stb.loadEn      = clkRise & ceLine;
        stb.passLive    = 1'b0;
        stb.modeClocked = 1'b1;
      end
      MODE_LATCHED: begin
        stb.loadEn   = ceLine;
        stb.passLive = ceLine;
      end
      default: begin // pass-through and the reserved code
        stb.loadEn   = 1'b0;
        stb.passLive = 1'b1;
      end
    endcase
    stb.inPath   = (dirQ == DIR_IN)  || (dirQ == DIR_BIDIR);
    stb.outPath  = (dirQ == DIR_OUT) || (dirQ == DIR_BIDIR);
    stb.inPass   = stb.inPath & ieLine;
    stb.outDrive = stb.outPath & oeLine;
  end

  // R2: a strobed word is in force at the next edge
  a_r2_cfg_load: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> (cfgQ == $past(cfgData)));

  // R6: one pool-clock rise gives at most one registered capture
  a_r6_single_capture: assert property (@(posedge clk) disable iff (!rstN)
    (stb.modeClocked && stb.loadEn && !cfgWe) |=> !stb.loadEn);

endmodule

// File: rtl/iocell_lane.sv
module iocell_lane #(
  parameter int DATA_W = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic              passLive,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] stored;

  always_ff @(posedge clk) begin
    if (!rstN)       stored <= '0;
    else if (loadEn) stored <= d;
  end

  assign q = passLive ? d : stored;

  // R8: an open window leaves the last live value in storage
  a_r8_store_follows: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> (stored == $past(d)));

endmodule

// File: rtl/iocell_datapath.sv
module iocell_datapath
  import iocell_pkg::*;
#(
  parameter int DATA_W = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] pinIn,
  input  logic [DATA_W-1:0] xbarIn,
  output logic [DATA_W-1:0] pinOut,
  output logic              pinOe,
  output logic [DATA_W-1:0] xbarOut
);
  logic [DATA_W-1:0] laneD [NUM_LANES];
  logic [DATA_W-1:0] laneQ [NUM_LANES];

  assign laneD[LANE_IN]  = pinIn;
  assign laneD[LANE_OUT] = xbarIn;

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    iocell_lane #(.DATA_W(DATA_W)) uLane (
      .clk     (clk),
      .rstN    (rstN),
      .loadEn  (stb.loadEn),
      .passLive(stb.passLive),
      .d       (laneD[g]),
      .q       (laneQ[g])
    );
  end

  assign xbarOut = stb.inPass  ? laneQ[LANE_IN]  : '0;
  assign pinOut  = stb.outPath ? laneQ[LANE_OUT] : '0;
  assign pinOe   = stb.outDrive;

endmodule

// File: rtl/iocell_top.sv
module iocell_top
  import iocell_pkg::*;
#(
  parameter int DATA_W  = 1,
  parameter int NUM_CLK = 2,
  parameter int NUM_EN  = 4,
  parameter int NUM_OE  = 4,
  localparam int CLK_SEL_W = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1,
  localparam int EN_SEL_W  = (NUM_EN  > 1) ? $clog2(NUM_EN)  : 1,
  localparam int OE_SEL_W  = (NUM_OE  > 1) ? $clog2(NUM_OE)  : 1,
  localparam int CFG_W     = 4 + CLK_SEL_W + 2 * EN_SEL_W + OE_SEL_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [CFG_W-1:0]   cfgData,
  input  logic [NUM_CLK-1:0] clkPool,
  input  logic [NUM_EN-1:0]  enPool,
  input  logic [NUM_OE-1:0]  oePool,
  input  logic [DATA_W-1:0]  pinIn,
  input  logic [DATA_W-1:0]  xbarIn,
  output logic [DATA_W-1:0]  pinOut,
  output logic               pinOe,
  output logic [DATA_W-1:0]  xbarOut
);
  strobe_t stb;

  iocell_ctrl #(.NUM_CLK(NUM_CLK), .NUM_EN(NUM_EN), .NUM_OE(NUM_OE)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .clkPool(clkPool), .enPool(enPool), .oePool(oePool), .stb(stb)
  );

  iocell_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .pinIn(pinIn), .xbarIn(xbarIn),
    .pinOut(pinOut), .pinOe(pinOe), .xbarOut(xbarOut)
  );

  // R3: no drive toward the pin without an outbound direction
  a_r3_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    !stb.outPath |-> (!pinOe && pinOut == '0));

  // R9: input enable low silences the crossbar side
  a_r9_ie_gate: assert property (@(posedge clk) disable iff (!rstN)
    !stb.inPass |-> (xbarOut == '0));

  // R5: an open live path shows the pin value on the crossbar side
  a_r5_live_path: assert property (@(posedge clk) disable iff (!rstN)
    (stb.passLive && stb.inPass) |-> (xbarOut == pinIn));

  // R6: no capture strobe in registered mode means the pin data holds
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stb.modeClocked && !stb.loadEn && !cfgWe && stb.outPath) |=> $stable(pinOut));

endmodule

// File: tb/tb_iocell_top.sv
`timescale 1ns/1ps
module tb_iocell_top;
  localparam int DW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [10:0] cfgData = '0;
  logic [1:0] clkPool = '0;
  logic [3:0] enPool = '0;
  logic [3:0] oePool = '0;
  logic [DW-1:0] pinIn = '0;
  logic [DW-1:0] xbarIn = '0;
  logic [DW-1:0] pinOut;
  logic pinOe;
  logic [DW-1:0] xbarOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // expected-item queues (scoreboard)
  logic [DW-1:0] qX[$];
  logic [DW-1:0] qP[$];
  logic          qO[$];
  string         qTag[$];
  event chkEv;

  always #2.5 clk = ~clk;

  iocell_top #(.DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .clkPool(clkPool), .enPool(enPool), .oePool(oePool),
    .pinIn(pinIn), .xbarIn(xbarIn),
    .pinOut(pinOut), .pinOe(pinOe), .xbarOut(xbarOut)
  );

  function automatic logic [10:0] mkCfg(logic [1:0] dir, logic [1:0] mode,
      logic clkS, logic [1:0] ceS, logic [1:0] ieS, logic [1:0] oeS);
    return {oeS, ieS, ceS, clkS, mode, dir};
  endfunction

  task automatic expectNow(logic [DW-1:0] ex, logic [DW-1:0] ep, logic eo, string tag);
    #1;
    qX.push_back(ex); qP.push_back(ep); qO.push_back(eo); qTag.push_back(tag);
    ->chkEv;
  endtask

  task automatic loadCfg(logic [10:0] v);
    @(negedge clk); cfgWe = 1'b1; cfgData = v;
    @(negedge clk); cfgWe = 1'b0;
  endtask

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      @(chkEv);
      while (qTag.size() > 0) begin
        logic [DW-1:0] ex, ep;
        logic eo;
        string tg;
        ex = qX.pop_front(); ep = qP.pop_front(); eo = qO.pop_front(); tg = qTag.pop_front();
        checks++;
        if (xbarOut !== ex || pinOut !== ep || pinOe !== eo) begin
          failures++;
          $display("FAIL %s: xbarOut=%h pinOut=%h pinOe=%b expected xbarOut=%h pinOut=%h pinOe=%b",
                   tg, xbarOut, pinOut, pinOe, ex, ep, eo);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expectNow(4'h0, 4'h0, 1'b0, "R1 in reset");
    @(negedge clk); rstN = 1'b1;
    pinIn = 4'hF; xbarIn = 4'hF; enPool = 4'hF; oePool = 4'hF;
    expectNow(4'h0, 4'h0, 1'b0, "R1 off after reset");

    // bidirectional pass-through, ie=1 oe=2
    loadCfg(mkCfg(2'b11, 2'b00, 1'b0, 2'd0, 2'd1, 2'd2));
    pinIn = 4'hA; xbarIn = 4'h5; enPool = 4'b0010; oePool = 4'b0100;
    expectNow(4'hA, 4'h5, 1'b1, "R5 R4 bidir pass");
    @(negedge clk); pinIn = 4'h3; xbarIn = 4'hC;
    expectNow(4'h3, 4'hC, 1'b1, "R5 same-cycle");
    @(negedge clk); oePool = 4'b1011;
    expectNow(4'h3, 4'hC, 1'b0, "R4 oe line low");
    @(negedge clk); oePool = 4'b0100; enPool = 4'b1101;
    expectNow(4'h0, 4'hC, 1'b1, "R9 ie low");

    // cfgData without strobe is ignored
    @(negedge clk); cfgData = mkCfg(2'b01, 2'b00, 1'b0, 2'd0, 2'd1, 2'd3); enPool = 4'b0010;
    @(posedge clk);
    expectNow(4'h3, 4'hC, 1'b1, "R2 no strobe");

    // input-only
    loadCfg(mkCfg(2'b01, 2'b00, 1'b0, 2'd0, 2'd1, 2'd3));
    oePool = 4'hF; enPool = 4'b0010; pinIn = 4'h6; xbarIn = 4'h9;
    expectNow(4'h6, 4'h0, 1'b0, "R3 input-only");

    // output-only, oe index 3
    loadCfg(mkCfg(2'b10, 2'b00, 1'b0, 2'd0, 2'd1, 2'd3));
    oePool = 4'b1000;
    expectNow(4'h0, 4'h9, 1'b1, "R3 R11 output-only oe3");

    // registered: clk 1, ce 3, ie 0, oe 0
    loadCfg(mkCfg(2'b11, 2'b01, 1'b1, 2'd3, 2'd0, 2'd0));
    enPool = 4'b1001; oePool = 4'b0001; clkPool = 2'b00; pinIn = 4'h6; xbarIn = 4'h9;
    expectNow(4'h0, 4'h0, 1'b1, "R6 before any rise");
    @(negedge clk); clkPool = 2'b10;
    @(posedge clk);
    expectNow(4'h6, 4'h9, 1'b1, "R6 R11 capture on rise");
    @(negedge clk); pinIn = 4'h7; xbarIn = 4'h1;
    @(posedge clk);
    expectNow(4'h6, 4'h9, 1'b1, "R6 no capture while high");
    @(negedge clk); clkPool = 2'b01;
    @(posedge clk);
    expectNow(4'h6, 4'h9, 1'b1, "R7 unselected clock");
    @(negedge clk); clkPool = 2'b00;
    @(negedge clk); enPool = 4'b0001; clkPool = 2'b10;
    @(posedge clk);
    expectNow(4'h6, 4'h9, 1'b1, "R6 enable low");
    @(negedge clk); clkPool = 2'b00; enPool = 4'b1001;
    @(negedge clk); clkPool = 2'b10; pinIn = 4'h8; xbarIn = 4'h2;
    @(posedge clk);
    expectNow(4'h8, 4'h2, 1'b1, "R6 second capture");
    @(negedge clk); enPool = 4'b1000;
    expectNow(4'h0, 4'h2, 1'b1, "R9 registered ie low");

    // transparent: ce 2, ie 0, oe 0
    loadCfg(mkCfg(2'b11, 2'b10, 1'b0, 2'd2, 2'd0, 2'd0));
    enPool = 4'b0001; pinIn = 4'hB; xbarIn = 4'h4;
    expectNow(4'h8, 4'h2, 1'b1, "R8 closed shows stored");
    @(negedge clk); enPool = 4'b0101;
    expectNow(4'hB, 4'h4, 1'b1, "R8 open");
    @(negedge clk); pinIn = 4'hD;
    expectNow(4'hD, 4'h4, 1'b1, "R8 follows input");
    @(negedge clk); enPool = 4'b0001; pinIn = 4'hE; xbarIn = 4'h6;
    expectNow(4'hD, 4'h4, 1'b1, "R8 holds after close");

    // reserved mode code
    loadCfg(mkCfg(2'b11, 2'b11, 1'b0, 2'd0, 2'd0, 2'd0));
    pinIn = 4'h1; xbarIn = 4'h2;
    expectNow(4'h1, 4'h2, 1'b1, "R10 reserved mode");

    #3;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule